// File: doc/BRIEF.md
# Privileged cache configuration register

This block is a single 32-bit control word for a cache memory system. Agents reach it over a simple register bus with an address-decoded read strobe and an address-decoded write strobe. Read-only status fields sit beside a small set of writable timing and protection controls in the same word. Some status fields are fixed by elaboration parameters. One is a live copy of an input pin that tells whether valid-RAM contents survive a hardware reset.

Each access carries a security-state flag and a privileged flag. Only a secure privileged agent can change the controls. A non-secure privileged agent can read the word, but its writes are dropped. An unprivileged agent reads zero and cannot write. A write is accepted only while the memory system reports itself idle. A permitted write that arrives while the memory system is busy is dropped and sets a sticky error flag.

The stored codes drive decoded outputs for the cache datapath: the setup and latency cycle counts of the tag RAM and the data RAM, and an ECC/parity enable.

Top module: `cache_cfg_reg`

## Requirements
- R1: After reset the writable fields are zero, so `eccEnable`=0, `tagSetupCycles`=0, `dataSetupCycles`=0, `tagLatCycles`=2 and `dataLatCycles`=2, and `wrBlockedErr`=0.
- R2: A write with `accSecure`=1, `accPriv`=1 and `memIdle`=1 loads the writable fields from `wrData`: bit 21 ECC enable, bit 9 tag setup, bits 8:6 tag latency code, bit 5 data setup, bits 2:0 data latency code. The new value is visible on `rdData` and on the decoded outputs from the cycle after the write edge.
- R3: With `accPriv`=1 and `accSecure`=0, a read returns the full word and a write changes nothing.
- R4: With `accPriv`=0, `rdData` is zero and a write changes nothing.
- R5: Bits 30:26, 22, 20:13 and 4:3 always read zero, whatever is written.
- R6: Bit 31 of a permitted read equals the current level of `validKeepPin`, and writes do not affect it.
- R7: Bits 25:24 read `NUM_CPU`-1, bit 23 reads `HAS_IRQ_CTRL`, bit 12 reads `TAG_SLICES` and bits 11:10 read `DATA_SLICES`. Writes do not change them.
- R8: When `HAS_ECC`=0, bit 21 reads zero and `eccEnable` stays 0 even after bit 21 is written as one.
- R9: A permitted write (secure and privileged) while `memIdle`=0 changes no field and sets `wrBlockedErr` from the next cycle. The flag stays set until reset. A write that is not permitted never sets it.
- R10: Tag latency codes decode to cycles as 0→2, 1→2, 2→3, 3→4 and 4–7→5. Data latency codes decode as 0→2 and otherwise to code+1. The setup outputs equal the stored setup bits.
- R11: A `DATA_SLICES` value above 2 (3 is the invalid encoding) or a `NUM_CPU` value outside 1–4 stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rdEn | input | 1 | Decoded read strobe |
| wrEn | input | 1 | Decoded write strobe |
| wrData | input | 32 | Write data |
| accSecure | input | 1 | Access comes from the secure state |
| accPriv | input | 1 | Access comes from a privileged level |
| memIdle | input | 1 | Memory system is idle |
| validKeepPin | input | 1 | Pin that disables hardware reset of valid-RAM contents |
| rdData | output | 32 | Read data, zero unless a privileged read is active |
| eccEnable | output | 1 | ECC/parity enable |
| tagSetupCycles | output | 1 | Tag RAM setup cycles |
| tagLatCycles | output | 4 | Tag RAM latency in cycles |
| dataSetupCycles | output | 1 | Data RAM setup cycles |
| dataLatCycles | output | 4 | Data RAM latency in cycles |
| wrBlockedErr | output | 1 | Sticky flag: a permitted write arrived while the memory system was busy |

## Verification
A stored field that is corrupt shows up as a wrong value on a decoded cycle-count output. Because the decode is combinational, this appears on the cycle after the faulty write edge, and the next permitted read shows it too. A fault in the access gate shows as a field that changes after a non-secure, unprivileged or busy write, or as non-zero data on an unprivileged read, so one access followed by a read exposes it. A fault in the sticky error flag shows either as the flag missing on the cycle after a blocked write, or as the flag set after a write that was not permitted.

// File: rtl/cache_cfg_pkg.sv
package cache_cfg_pkg;

  localparam int WORD_W = 32;
  localparam int LAT_W  = 3;
  localparam int CYC_W  = 4;

  // bit positions that software decodes
  localparam int POS_KEEP    = 31;
  localparam int POS_CPU_LO  = 24;
  localparam int POS_IRQC    = 23;
  localparam int POS_ECC     = 21;
  localparam int POS_TSLICE  = 12;
  localparam int POS_DSLC_LO = 10;
  localparam int POS_TSETUP  = 9;
  localparam int POS_TLAT_LO = 6;
  localparam int POS_DSETUP  = 5;
  localparam int POS_DLAT_LO = 0;

  localparam logic [WORD_W-1:0] RSV_MASK = 32'h7C5F_E018;

  typedef struct packed {
    logic wrAccept;
    logic wrBlocked;
    logic rdAllow;
  } ctrlStrobe_t;

  function automatic logic [CYC_W-1:0] tagLatDecode(input logic [LAT_W-1:0] code);
    if (code[LAT_W-1])        return CYC_W'(5);
    else if (code == '0)      return CYC_W'(2);
    else                      return CYC_W'(code) + CYC_W'(1);
  endfunction

  function automatic logic [CYC_W-1:0] dataLatDecode(input logic [LAT_W-1:0] code);
    if (code == '0) return CYC_W'(2);
    else            return CYC_W'(code) + CYC_W'(1);
  endfunction

endpackage

// File: rtl/cache_cfg_ctrl.sv
module cache_cfg_ctrl
  import cache_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic        accSecure,
  input  logic        accPriv,
  input  logic        memIdle,
  output ctrlStrobe_t strobe,
  output logic        wrBlockedErr
);

  logic wrPermit;

  always_comb begin
    wrPermit         = wrEn & accSecure & accPriv;
    strobe.wrAccept  = wrPermit & memIdle;
    strobe.wrBlocked = wrPermit & ~memIdle;
    strobe.rdAllow   = rdEn & accPriv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 wrBlockedErr <= 1'b0;
    else if (strobe.wrBlocked) wrBlockedErr <= 1'b1;
  end

  // R9: once set, the error flag stays set
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrBlockedErr |=> wrBlockedErr);

  // R9: a write that is not permitted cannot raise the flag
  a_r9_only_permitted: assert property (@(posedge clk) disable iff (!rstN)
    (!wrBlockedErr && !(wrEn && accSecure && accPriv)) |=> !wrBlockedErr);

endmodule

// File: rtl/cache_cfg_dpath.sv
module cache_cfg_dpath
  import cache_cfg_pkg::*;
#(
  parameter int NUM_CPU      = 4,
  parameter int HAS_IRQ_CTRL = 1,
  parameter int TAG_SLICES   = 1,
  parameter int DATA_SLICES  = 2,
  parameter int HAS_ECC      = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic              validKeepPin,
  output logic [WORD_W-1:0] regWord,
  output logic              eccEnable,
  output logic              tagSetupCycles,
  output logic [CYC_W-1:0]  tagLatCycles,
  output logic              dataSetupCycles,
  output logic [CYC_W-1:0]  dataLatCycles
);

  localparam logic [1:0] CPU_CODE  = 2'(NUM_CPU - 1);
  localparam logic [1:0] DSLC_CODE = 2'(DATA_SLICES);
  localparam logic       TSLC_CODE = 1'(TAG_SLICES);
  localparam logic       IRQC_CODE = 1'(HAS_IRQ_CTRL);

  logic             tagSetupQ, dataSetupQ, eccQ;
  logic [LAT_W-1:0] tagLatQ, dataLatQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tagSetupQ  <= 1'b0;
      dataSetupQ <= 1'b0;
      tagLatQ    <= '0;
      dataLatQ   <= '0;
    end else if (strobe.wrAccept) begin
      tagSetupQ  <= wrData[POS_TSETUP];
      dataSetupQ <= wrData[POS_DSETUP];
      tagLatQ    <= wrData[POS_TLAT_LO +: LAT_W];
      dataLatQ   <= wrData[POS_DLAT_LO +: LAT_W];
    end
  end

  generate
    if (HAS_ECC != 0) begin : g_ecc
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 eccQ <= 1'b0;
        else if (strobe.wrAccept)  eccQ <= wrData[POS_ECC];
      end
    end else begin : g_no_ecc
      assign eccQ = 1'b0;
    end
  endgenerate

  always_comb begin
    regWord                           = '0;
    regWord[POS_KEEP]                 = validKeepPin;
    regWord[POS_CPU_LO +: 2]          = CPU_CODE;
    regWord[POS_IRQC]                 = IRQC_CODE;
    regWord[POS_ECC]                  = eccQ;
    regWord[POS_TSLICE]               = TSLC_CODE;
    regWord[POS_DSLC_LO +: 2]         = DSLC_CODE;
    regWord[POS_TSETUP]               = tagSetupQ;
    regWord[POS_TLAT_LO +: LAT_W]     = tagLatQ;
    regWord[POS_DSETUP]               = dataSetupQ;
    regWord[POS_DLAT_LO +: LAT_W]     = dataLatQ;
  end

  assign eccEnable       = eccQ;
  assign tagSetupCycles  = tagSetupQ;
  assign dataSetupCycles = dataSetupQ;
  assign tagLatCycles    = tagLatDecode(tagLatQ);
  assign dataLatCycles   = dataLatDecode(dataLatQ);

  // R2: stored fields move only on an accepted write
  a_r2_hold_unless_accept: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrAccept |=> $stable(regWord[POS_ECC:0]));

  // R10: decoded latencies stay in their legal ranges
  a_r10_tag_range: assert property (@(posedge clk) disable iff (!rstN)
    (tagLatCycles >= CYC_W'(2)) && (tagLatCycles <= CYC_W'(5)));
  a_r10_data_range: assert property (@(posedge clk) disable iff (!rstN)
    (dataLatCycles >= CYC_W'(2)) && (dataLatCycles <= CYC_W'(8)));

endmodule

// File: rtl/cache_cfg_reg.sv
module cache_cfg_reg
  import cache_cfg_pkg::*;
#(
  parameter int NUM_CPU      = 4,
  parameter int HAS_IRQ_CTRL = 1,
  parameter int TAG_SLICES   = 1,
  parameter int DATA_SLICES  = 2,
  parameter int HAS_ECC      = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdEn,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic        accSecure,
  input  logic        accPriv,
  input  logic        memIdle,
  input  logic        validKeepPin,
  output logic [31:0] rdData,
  output logic        eccEnable,
  output logic        tagSetupCycles,
  output logic [3:0]  tagLatCycles,
  output logic        dataSetupCycles,
  output logic [3:0]  dataLatCycles,
  output logic        wrBlockedErr
);

  // R11: reject illegal configurations at elaboration
  generate
    if (DATA_SLICES < 0 || DATA_SLICES > 2) begin : g_bad_dslc
      $error("cache_cfg_reg: DATA_SLICES must be 0..2");
    end
    if (NUM_CPU < 1 || NUM_CPU > 4) begin : g_bad_cpu
      $error("cache_cfg_reg: NUM_CPU must be 1..4");
    end
  endgenerate

  ctrlStrobe_t       strobe;
  logic [WORD_W-1:0] regWord;

  cache_cfg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .rdEn        (rdEn),
    .wrEn        (wrEn),
    .accSecure   (accSecure),
    .accPriv     (accPriv),
    .memIdle     (memIdle),
    .strobe      (strobe),
    .wrBlockedErr(wrBlockedErr)
  );

  cache_cfg_dpath #(
    .NUM_CPU     (NUM_CPU),
    .HAS_IRQ_CTRL(HAS_IRQ_CTRL),
    .TAG_SLICES  (TAG_SLICES),
    .DATA_SLICES (DATA_SLICES),
    .HAS_ECC     (HAS_ECC)
  ) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .wrData         (wrData),
    .validKeepPin   (validKeepPin),
    .regWord        (regWord),
    .eccEnable      (eccEnable),
    .tagSetupCycles (tagSetupCycles),
    .tagLatCycles   (tagLatCycles),
    .dataSetupCycles(dataSetupCycles),
    .dataLatCycles  (dataLatCycles)
  );

  assign rdData = strobe.rdAllow ? regWord : '0;

  // R4: unprivileged reads see zero
  a_r4_unpriv_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !accPriv) |-> (rdData == '0));

  // R5: reserved bits never read as one
  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & RSV_MASK) == '0);

  // R6: a permitted read reflects the live pin
  a_r6_pin_live: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && accPriv) |-> (rdData[POS_KEEP] == validKeepPin));

  // R3: a non-secure write leaves every decoded output unchanged
  a_r3_nonsecure_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !accSecure) |=> ($stable(tagLatCycles) && $stable(dataLatCycles)
      && $stable(eccEnable) && $stable(tagSetupCycles) && $stable(dataSetupCycles)));

  // R9: a write while busy leaves every decoded output unchanged
  a_r9_busy_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !memIdle) |=> ($stable(tagLatCycles) && $stable(dataLatCycles)
      && $stable(eccEnable) && $stable(tagSetupCycles) && $stable(dataSetupCycles)));

endmodule

// File: tb/cache_cfg_reg_tb.sv
module cache_cfg_reg_tb;

  localparam int NCPU = 4, IRQC = 1, TSL = 1, DSL = 2;
  localparam logic [31:0] CFG_BITS = (32'(NCPU - 1) << 24) | (32'(IRQC) << 23)
                                   | (32'(TSL) << 12) | (32'(DSL) << 10);
  localparam logic [31:0] WR_MASK_ECC   = 32'h0020_03E7;
  localparam logic [31:0] WR_MASK_NOECC = 32'h0000_03E7;

  logic        clk = 1'b0, rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0, accSecure = 1'b0, accPriv = 1'b0;
  logic        memIdle = 1'b1, validKeepPin = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataN;
  logic        eccEnable, tagSetupCycles, dataSetupCycles, wrBlockedErr;
  logic [3:0]  tagLatCycles, dataLatCycles;
  logic        eccEnableN, tagSetupN, dataSetupN, wrBlockedErrN;
  logic [3:0]  tagLatN, dataLatN;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cache_cfg_reg #(.NUM_CPU(NCPU), .HAS_IRQ_CTRL(IRQC), .TAG_SLICES(TSL),
                  .DATA_SLICES(DSL), .HAS_ECC(1)) u_dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .accSecure(accSecure), .accPriv(accPriv), .memIdle(memIdle),
    .validKeepPin(validKeepPin), .rdData(rdData), .eccEnable(eccEnable),
    .tagSetupCycles(tagSetupCycles), .tagLatCycles(tagLatCycles),
    .dataSetupCycles(dataSetupCycles), .dataLatCycles(dataLatCycles),
    .wrBlockedErr(wrBlockedErr));

  cache_cfg_reg #(.NUM_CPU(NCPU), .HAS_IRQ_CTRL(IRQC), .TAG_SLICES(TSL),
                  .DATA_SLICES(DSL), .HAS_ECC(0)) u_dut_noecc (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .accSecure(accSecure), .accPriv(accPriv), .memIdle(memIdle),
    .validKeepPin(validKeepPin), .rdData(rdDataN), .eccEnable(eccEnableN),
    .tagSetupCycles(tagSetupN), .tagLatCycles(tagLatN),
    .dataSetupCycles(dataSetupN), .dataLatCycles(dataLatN),
    .wrBlockedErr(wrBlockedErrN));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic sec, input logic priv,
                         input logic idle);
    @(negedge clk);
    wrData = d; accSecure = sec; accPriv = priv; memIdle = idle; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; memIdle = 1'b1;
  endtask

  task automatic doRead(input logic sec, input logic priv, output logic [31:0] v,
                        output logic [31:0] vN);
    @(negedge clk);
    accSecure = sec; accPriv = priv; rdEn = 1'b1;
    #1 v = rdData; vN = rdDataN;
    rdEn = 1'b0;
  endtask

  function automatic logic [3:0] expTag(input int c);
    if (c >= 4) return 4'd5;
    if (c < 2)  return 4'd2;
    return 4'(c + 1);
  endfunction

  function automatic logic [3:0] expData(input int c);
    if (c < 2) return 4'd2;
    return 4'(c + 1);
  endfunction

  task automatic testReset();
    logic [31:0] v, vN;
    chk("R1 ecc", 32'(eccEnable), 0);
    chk("R1 tagSetup", 32'(tagSetupCycles), 0);
    chk("R1 tagLat", 32'(tagLatCycles), 2);
    chk("R1 dataSetup", 32'(dataSetupCycles), 0);
    chk("R1 dataLat", 32'(dataLatCycles), 2);
    chk("R1 err", 32'(wrBlockedErr), 0);
    doRead(1, 1, v, vN);
    chk("R1 R7 word", v, CFG_BITS);
  endtask

  task automatic testSecureWrite();
    logic [31:0] v, vN;
    doWrite(32'hFFFF_FFFF, 1, 1, 1);
    doRead(1, 1, v, vN);
    chk("R2 R5 R7 all-ones", v, CFG_BITS | WR_MASK_ECC);
    chk("R8 noecc all-ones", vN, CFG_BITS | WR_MASK_NOECC);
    chk("R2 ecc", 32'(eccEnable), 1);
    chk("R8 ecc absent", 32'(eccEnableN), 0);
    chk("R10 setup tag", 32'(tagSetupCycles), 1);
    chk("R10 setup data", 32'(dataSetupCycles), 1);
    doWrite(32'h0000_0000, 1, 1, 1);
    doRead(1, 1, v, vN);
    chk("R2 clear", v, CFG_BITS);
  endtask

  task automatic testNonSecure();
    logic [31:0] v, vN;
    doWrite(32'h0020_0145, 1, 1, 1);
    doWrite(32'hFFFF_FFFF, 0, 1, 1);
    doRead(0, 1, v, vN);
    chk("R3 ns read/write ignored", v, CFG_BITS | 32'h0020_0145);
    chk("R9 ns no err", 32'(wrBlockedErr), 0);
  endtask

  task automatic testUnpriv();
    logic [31:0] v, vN;
    doWrite(32'h0000_0000, 1, 0, 1);
    doRead(1, 0, v, vN);
    chk("R4 unpriv read", v, 0);
    doRead(1, 1, v, vN);
    chk("R4 unpriv write ignored", v, CFG_BITS | 32'h0020_0145);
  endtask

  task automatic testPin();
    logic [31:0] v, vN;
    validKeepPin = 1'b1;
    doRead(1, 1, v, vN);
    chk("R6 pin high", 32'(v[31]), 1);
    doWrite(32'h0000_0000, 1, 1, 1);
    doRead(1, 1, v, vN);
    chk("R6 pin not writable", v, 32'h8000_0000 | CFG_BITS);
    validKeepPin = 1'b0;
    doRead(0, 1, v, vN);
    chk("R6 pin low", 32'(v[31]), 0);
  endtask

  task automatic testDecode();
    for (int c = 0; c < 8; c++) begin
      doWrite(32'(c << 6) | 32'(c), 1, 1, 1);
      chk($sformatf("R10 tag code %0d", c), 32'(tagLatCycles), 32'(expTag(c)));
      chk($sformatf("R10 data code %0d", c), 32'(dataLatCycles), 32'(expData(c)));
    end
  endtask

  task automatic testBusy();
    logic [31:0] v, vN;
    doWrite(32'h0000_0000, 1, 1, 1);
    doWrite(32'h0000_0000, 1, 0, 0);
    chk("R9 unpriv busy no err", 32'(wrBlockedErr), 0);
    doWrite(32'h0020_03E7, 1, 1, 0);
    doRead(1, 1, v, vN);
    chk("R9 busy write dropped", v, CFG_BITS);
    chk("R9 err set", 32'(wrBlockedErr), 1);
    doWrite(32'h0000_0003, 1, 1, 1);
    chk("R9 err sticky", 32'(wrBlockedErr), 1);
    chk("R9 idle write after", 32'(dataLatCycles), 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSecureWrite();
    testNonSecure();
    testUnpriv();
    testPin();
    testDecode();
    testBusy();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule